// File: doc/BRIEF.md
# Boundary Scan Pin Register

This block is the boundary-scan data path for a device with a parameterised number of bidirectional pins. Every pin owns three scan cells: one for the pad input, one for the value driven toward the pad and one for the pad drive enable. All cells form a single serial chain between `tdi` and `tdo`. A two-bit instruction register chooses among three modes: observe-and-preload, external test, and a single-flop bypass.

Sequencing comes from an external TAP controller as decoded strobes on `tck`: capture, shift and update for both the data side and the instruction side, plus a synchronous test-logic-reset. Shift registers advance on the rising edge of `tck`. `tdo` is re-timed on the falling edge, so a tester that samples on the rising edge sees each bit for a full half period. In the observe mode the core-to-pad path stays untouched. In external test the pads and the core input are driven from the update latches, which fully isolates the core.

The serial path is a plain bit stream with no valid/ready handshake. The TAP strobes are the only flow control: a bit moves only in a cycle where a shift strobe is high, and the bench never raises a data strobe and an instruction strobe together.

Top module: `bscan_pin_reg`

## Requirements
- R1: While `tap_reset` is high at a rising edge, the instruction becomes bypass (`2'b11`) and all update latches clear. A later load of external test with no data update therefore drives every pad output, pad enable and core input to 0.
- R2: Capture-IR loads the pattern `2'b01` into the instruction shift stage. Shift-IR then sends it out on `tdo` least significant bit first (1, then 0), while `tdi` enters at the most significant end.
- R3: Code `2'b11`, and the undefined code `2'b10`, select bypass. Capture-DR clears the bypass flop, so the first bit out is 0, and each later bit out equals the `tdi` bit shifted one clock earlier.
- R4: In observe mode (code `2'b01`), capture-DR loads chain bit 3p with `pad_in[p]`, bit 3p+1 with the value driven on `pad_out[p]` and bit 3p+2 with `pad_oe[p]`. Bit 0 leaves on `tdo` first, and `tdi` enters at bit 3N-1.
- R5: Outside external test, `pad_out` equals `core_out`, `pad_oe` equals `core_oe` and `core_in` equals `pad_in` in every cycle, including shift and update cycles.
- R6: In external test (code `2'b00`), `pad_out[p]`, `pad_oe[p]` and `core_in[p]` follow update bits 3p+1, 3p+2 and 3p. The update bits equal the chain contents at the last update-DR.
- R7: In external test, capture-DR samples the live pad input and the driven pad values, and these are shifted out while the new drive pattern is shifted in.
- R8: Update latches change only on update-DR under an observe or external-test instruction. Shifting without update-DR, or an update-DR under bypass, leaves the pads unchanged.
- R9: A pattern loaded by update-DR in observe mode appears on the pads as soon as update-IR selects external test.
- R10: `tdo` changes only on the falling edge of `tck`. Its value just after a rising edge equals its value just before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| tap_reset | input | 1 | Synchronous test-logic-reset strobe |
| cap_dr | input | 1 | Capture-DR strobe |
| sh_dr | input | 1 | Shift-DR strobe |
| upd_dr | input | 1 | Update-DR strobe |
| cap_ir | input | 1 | Capture-IR strobe |
| sh_ir | input | 1 | Shift-IR strobe |
| upd_ir | input | 1 | Update-IR strobe |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out, falling-edge timed |
| core_out | input | NPINS | Core drive values toward pads |
| core_oe | input | NPINS | Core drive enables |
| core_in | output | NPINS | Pad values delivered to the core |
| pad_in | input | NPINS | Values present at the pads |
| pad_out | output | NPINS | Drive values to the pad buffers |
| pad_oe | output | NPINS | Drive enables to the pad buffers |

## Verification
Two functions can fall in the same cycle: an update-DR that preloads the latches in observe mode, and the live core traffic that those same latches must not disturb. The bench changes `core_out`, `core_oe` and `pad_in` to fresh random values right before every capture and every update. After each update it checks that the pads still mirror the core. A later switch to external test must then show exactly the preloaded pattern. In external test, each scan both reads out the previously driven pattern and installs the next one. The bench judges both halves of that exchange against its own model of the chain order.

// File: rtl/bscan_pkg.sv
package bscan_pkg;
  localparam int IR_W          = 2;
  localparam int CELLS_PER_PIN = 3;
  localparam int CELL_IN       = 0;
  localparam int CELL_OUT      = 1;
  localparam int CELL_OE       = 2;

  typedef enum logic [IR_W-1:0] {
    IR_EXTEST = 2'b00,
    IR_SAMPLE = 2'b01,
    IR_UNDEF  = 2'b10,
    IR_BYPASS = 2'b11
  } ir_code_e;

  localparam logic [IR_W-1:0] IR_CAPTURE_PAT = 2'b01;
endpackage

// File: rtl/bscan_ir.sv
module bscan_ir
  import bscan_pkg::*;
(
  input  logic tck,
  input  logic tap_reset,
  input  logic cap_ir,
  input  logic sh_ir,
  input  logic upd_ir,
  input  logic tdi,
  output logic ir_lsb,
  output logic sel_chain,
  output logic sel_extest
);
  logic [IR_W-1:0] ir_sr;
  logic [IR_W-1:0] ir_q;

  always_ff @(posedge tck) begin
    if (tap_reset) begin
      ir_sr <= IR_CAPTURE_PAT;
      ir_q  <= IR_BYPASS;
    end else begin
      if (cap_ir)      ir_sr <= IR_CAPTURE_PAT;
      else if (sh_ir)  ir_sr <= {tdi, ir_sr[IR_W-1:1]};
      if (upd_ir)      ir_q  <= ir_sr;
    end
  end

  assign ir_lsb = ir_sr[0];

  always_comb begin
    sel_chain  = 1'b0;
    sel_extest = 1'b0;
    case (ir_q)
      IR_EXTEST: begin sel_chain = 1'b1; sel_extest = 1'b1; end
      IR_SAMPLE: sel_chain = 1'b1;
      default:   ;
    endcase
  end

  // R2
  ir_capture_chk: assert property (@(posedge tck) disable iff (tap_reset)
    cap_ir |=> ir_sr == IR_CAPTURE_PAT);

  // R1
  ir_reset_chk: assert property (@(posedge tck)
    tap_reset |=> ir_q == IR_BYPASS);

  // R8
  ir_hold_chk: assert property (@(posedge tck) disable iff (tap_reset)
    !upd_ir |=> $stable(ir_q));
endmodule

// File: rtl/bscan_cells.sv
module bscan_cells
  import bscan_pkg::*;
#(
  parameter int NPINS = 4
) (
  input  logic             tck,
  input  logic             tap_reset,
  input  logic             cap_dr,
  input  logic             sh_dr,
  input  logic             upd_dr,
  input  logic             sel_chain,
  input  logic             sel_extest,
  input  logic             tdi,
  input  logic [NPINS-1:0] core_out,
  input  logic [NPINS-1:0] core_oe,
  output logic [NPINS-1:0] core_in,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe,
  output logic             chain_lsb
);
  localparam int LEN = NPINS * CELLS_PER_PIN;

  logic [LEN-1:0] shift_q;
  logic [LEN-1:0] hold_q;
  logic [LEN-1:0] snap;

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    localparam int B = p * CELLS_PER_PIN;
    assign pad_out[p]          = sel_extest ? hold_q[B+CELL_OUT] : core_out[p];
    assign pad_oe[p]           = sel_extest ? hold_q[B+CELL_OE]  : core_oe[p];
    assign core_in[p]          = sel_extest ? hold_q[B+CELL_IN]  : pad_in[p];
    assign snap[B+CELL_IN]     = pad_in[p];
    assign snap[B+CELL_OUT]    = pad_out[p];
    assign snap[B+CELL_OE]     = pad_oe[p];
  end

  always_ff @(posedge tck) begin
    if (cap_dr && sel_chain)     shift_q <= snap;
    else if (sh_dr && sel_chain) shift_q <= {tdi, shift_q[LEN-1:1]};
  end

  always_ff @(posedge tck) begin
    if (tap_reset)                hold_q <= '0;
    else if (upd_dr && sel_chain) hold_q <= shift_q;
  end

  assign chain_lsb = shift_q[0];

  // R4
  cell_capture_chk: assert property (@(posedge tck) disable iff (tap_reset)
    cap_dr && sel_chain |=> shift_q == $past(snap));

  // R7
  cell_shift_chk: assert property (@(posedge tck) disable iff (tap_reset)
    sh_dr && sel_chain && !cap_dr |=> shift_q[LEN-1] == $past(tdi));

  // R8
  cell_hold_chk: assert property (@(posedge tck) disable iff (tap_reset)
    !(upd_dr && sel_chain) |=> $stable(hold_q));
endmodule

// File: rtl/bscan_pin_reg.sv
module bscan_pin_reg
  import bscan_pkg::*;
#(
  parameter int NPINS = 4
) (
  input  logic             tck,
  input  logic             tap_reset,
  input  logic             cap_dr,
  input  logic             sh_dr,
  input  logic             upd_dr,
  input  logic             cap_ir,
  input  logic             sh_ir,
  input  logic             upd_ir,
  input  logic             tdi,
  output logic             tdo,
  input  logic [NPINS-1:0] core_out,
  input  logic [NPINS-1:0] core_oe,
  output logic [NPINS-1:0] core_in,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe
);
  logic ir_lsb, sel_chain, sel_extest, chain_lsb;
  logic byp_q, tdo_q;

  bscan_ir u_ir (
    .tck(tck), .tap_reset(tap_reset), .cap_ir(cap_ir), .sh_ir(sh_ir),
    .upd_ir(upd_ir), .tdi(tdi), .ir_lsb(ir_lsb),
    .sel_chain(sel_chain), .sel_extest(sel_extest)
  );

  bscan_cells #(.NPINS(NPINS)) u_cells (
    .tck(tck), .tap_reset(tap_reset), .cap_dr(cap_dr), .sh_dr(sh_dr),
    .upd_dr(upd_dr), .sel_chain(sel_chain), .sel_extest(sel_extest),
    .tdi(tdi), .core_out(core_out), .core_oe(core_oe), .core_in(core_in),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .chain_lsb(chain_lsb)
  );

  always_ff @(posedge tck) begin
    if (tap_reset)                 byp_q <= 1'b0;
    else if (cap_dr && !sel_chain) byp_q <= 1'b0;
    else if (sh_dr && !sel_chain)  byp_q <= tdi;
  end

  always_ff @(negedge tck) begin
    if (sh_ir)      tdo_q <= ir_lsb;
    else if (sh_dr) tdo_q <= sel_chain ? chain_lsb : byp_q;
  end

  assign tdo = tdo_q;

  // R3
  byp_shift_chk: assert property (@(posedge tck) disable iff (tap_reset)
    sh_dr && !cap_dr && !sel_chain |=> byp_q == $past(tdi));

  // R3
  byp_capture_chk: assert property (@(posedge tck) disable iff (tap_reset)
    cap_dr && !sel_chain |=> !byp_q);
endmodule

// File: tb/tb_bscan_pin_reg.sv
module tb_bscan_pin_reg;
  localparam int CLK_P = 10;
  localparam int N     = 4;
  localparam int L     = 3 * N;

  logic tck = 1'b0;
  always #(CLK_P/2) tck = ~tck;

  logic tap_reset = 1'b1;
  logic cap_dr = 1'b0, sh_dr = 1'b0, upd_dr = 1'b0;
  logic cap_ir = 1'b0, sh_ir = 1'b0, upd_ir = 1'b0;
  logic tdi = 1'b0;
  logic tdo;
  logic [N-1:0] core_out = '0, core_oe = '0, pad_in = '0;
  logic [N-1:0] core_in, pad_out, pad_oe;

  int total = 0;
  int bad = 0;
  int edge_slips = 0;
  bit done = 0;

  bscan_pin_reg #(.NPINS(N)) dut (
    .tck(tck), .tap_reset(tap_reset), .cap_dr(cap_dr), .sh_dr(sh_dr),
    .upd_dr(upd_dr), .cap_ir(cap_ir), .sh_ir(sh_ir), .upd_ir(upd_ir),
    .tdi(tdi), .tdo(tdo), .core_out(core_out), .core_oe(core_oe),
    .core_in(core_in), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  function automatic logic [L-1:0] exp_cap(logic [N-1:0] pi, logic [N-1:0] po,
                                           logic [N-1:0] poe);
    logic [L-1:0] v;
    for (int p = 0; p < N; p++) begin
      v[3*p]   = pi[p];
      v[3*p+1] = po[p];
      v[3*p+2] = poe[p];
    end
    return v;
  endfunction

  function automatic logic [N-1:0] field(logic [L-1:0] v, int off);
    logic [N-1:0] f;
    for (int p = 0; p < N; p++) f[p] = v[3*p+off];
    return f;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge tck);
    #1;
  endtask

  task automatic scan_dr(input logic [L-1:0] din, input bit do_upd,
                         output logic [L-1:0] dout);
    cap_dr = 1'b1; tick(); cap_dr = 1'b0;
    for (int i = 0; i < L; i++) begin
      sh_dr = 1'b1; tdi = din[i];
      #(CLK_P-3);
      dout[i] = tdo;
      tick();
      if (tdo !== dout[i]) edge_slips++;
    end
    sh_dr = 1'b0;
    if (do_upd) begin upd_dr = 1'b1; tick(); upd_dr = 1'b0; end
  endtask

  task automatic load_ir(input logic [1:0] code, output logic [1:0] capt);
    cap_ir = 1'b1; tick(); cap_ir = 1'b0;
    for (int i = 0; i < 2; i++) begin
      sh_ir = 1'b1; tdi = code[i];
      #(CLK_P-3);
      capt[i] = tdo;
      tick();
      if (tdo !== capt[i]) edge_slips++;
    end
    sh_ir = 1'b0;
    upd_ir = 1'b1; tick(); upd_ir = 1'b0;
  endtask

  task automatic randomize_core();
    core_out = N'($urandom);
    core_oe  = N'($urandom);
    pad_in   = N'($urandom);
  endtask

  initial begin
    repeat (100000) @(posedge tck);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [1:0] ic;
    logic [L-1:0] din, dout, last_drv, preload;
    int seed_init;
    seed_init = $urandom(32'd4711);
    tick(); tick();
    tap_reset = 1'b0;

    // R5: after reset the instruction is bypass, pads are transparent
    randomize_core(); #1;
    chk("R5 reset transparent", {pad_out, pad_oe, core_in}, {core_out, core_oe, pad_in});

    // R2: capture pattern on IR, R1: cleared latches in EXTEST
    load_ir(2'b00, ic);
    chk("R2 ir capture", ic, 2'b01);
    chk("R1 cleared latches", {pad_out, pad_oe, core_in}, '0);

    // R8: shift without update keeps pads
    din = L'($urandom);
    randomize_core();
    scan_dr(din, 1'b0, dout);
    chk("R7 extest capture of zero drive", dout, exp_cap(pad_in, '0, '0));
    chk("R8 no update no change", {pad_out, pad_oe, core_in}, '0);

    // R6/R7: random extest exchanges
    last_drv = '0;
    for (int it = 0; it < 20; it++) begin
      din = L'($urandom);
      if (it == 0) din = '1;
      if (it == 1) din = '0;
      randomize_core();
      scan_dr(din, 1'b1, dout);
      chk("R7 extest capture", dout,
          exp_cap(pad_in, field(last_drv, 1), field(last_drv, 2)));
      chk("R6 extest drive", {pad_out, pad_oe, core_in},
          {field(din, 1), field(din, 2), field(din, 0)});
      last_drv = din;
    end

    // R4/R5: observe mode with live traffic, preload in same cycles
    load_ir(2'b01, ic);
    chk("R2 ir capture again", ic, 2'b01);
    randomize_core(); #1;
    chk("R5 sample transparent", {pad_out, pad_oe, core_in}, {core_out, core_oe, pad_in});
    preload = '0;
    for (int it = 0; it < 20; it++) begin
      din = L'($urandom);
      randomize_core();
      scan_dr(din, 1'b1, dout);
      chk("R4 sample capture", dout, exp_cap(pad_in, core_out, core_oe));
      randomize_core(); #1;
      chk("R5 transparent after preload", {pad_out, pad_oe, core_in},
          {core_out, core_oe, pad_in});
      preload = din;
    end

    // R9: preloaded pattern appears on switch to extest
    load_ir(2'b00, ic);
    chk("R9 preload drive", {pad_out, pad_oe, core_in},
        {field(preload, 1), field(preload, 2), field(preload, 0)});

    // R3: bypass codes 11 and 10
    for (int k = 0; k < 2; k++) begin
      load_ir(k == 0 ? 2'b11 : 2'b10, ic);
      for (int it = 0; it < 5; it++) begin
        din = L'($urandom);
        scan_dr(din, 1'b1, dout);
        chk("R3 bypass stream", dout, {din[L-2:0], 1'b0});
      end
      randomize_core(); #1;
      chk("R5 bypass transparent", {pad_out, pad_oe, core_in},
          {core_out, core_oe, pad_in});
    end

    // R8: updates under bypass left the latches alone
    load_ir(2'b00, ic);
    chk("R8 bypass update ignored", {pad_out, pad_oe, core_in},
        {field(preload, 1), field(preload, 2), field(preload, 0)});

    // R1: reset in the middle of external test
    tap_reset = 1'b1; tick(); tap_reset = 1'b0;
    randomize_core(); #1;
    chk("R1 reset to bypass transparent", {pad_out, pad_oe, core_in},
        {core_out, core_oe, pad_in});
    din = L'($urandom);
    scan_dr(din, 1'b0, dout);
    chk("R1 reset selects bypass", dout, {din[L-2:0], 1'b0});
    load_ir(2'b00, ic);
    chk("R1 latches cleared by reset", {pad_out, pad_oe, core_in}, '0);

    // R10: tdo never moved at a rising edge
    chk("R10 tdo falling edge", edge_slips, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule